// File: doc/BRIEF.md
# SMART Subcommand Gating Controller

This block sits behind a disk controller's command decoder. It turns a SMART function request into a status and a set of action pulses. Each request arrives as a one-cycle strobe. The strobe carries the subcommand byte, which the host placed in its Features register, together with the Sector Count and LBA Low bytes that qualify it. One cycle later the block raises a done pulse. With it comes either an accept or an abort-with-error indication. Any side effect is signalled in the same cycle: an attribute save request, an off-line start with its operation code, or a change of the enabled and automatic off-line flags. For a status query, a threshold-compare pulse follows one cycle after the save pulse.

The enabled flag and the automatic off-line flag must survive power cycles. They are modelled as registers that take their values from persistent-state inputs while reset is held. Firmware observes both flags on outputs and writes them back to non-volatile storage. Attribute storage, threshold arithmetic and the host bus protocol belong to other blocks.

Top module: `smart_gate`

## Requirements
- R1: While `rst_n` is low at a clock edge, `smart_en_o` takes `nv_en_i` and `auto_off_o` takes `nv_auto_i`, and done, status and action outputs are 0 after that edge.
- R2: A strobe at clock edge N produces `rsp_done_o` high for exactly the cycle after edge N, with exactly one of `rsp_ok_o` and `rsp_err_o` high. Without a strobe, `rsp_done_o` stays low.
- R3: While `smart_en_o` is 0, every subcommand except D8h is aborted (`rsp_err_o`=1). No save, compare or off-line pulse is produced, and neither flag changes.
- R4: D8h is accepted and sets `smart_en_o`. When SMART is already enabled, D8h leaves both flags unchanged.
- R5: D9h while enabled is accepted and clears `smart_en_o`. `auto_off_o` is not changed.
- R6: DBh while enabled behaves as follows. With Sector Count 00h it is accepted and clears `auto_off_o`. With F8h it is accepted and sets `auto_off_o`. With any other value it is aborted and `auto_off_o` is unchanged.
- R7: D3h while enabled is accepted and raises `save_o` together with the done pulse.
- R8: DAh while enabled is accepted and raises `save_o` together with the done pulse. `cmp_o` is raised in the following cycle, and `cmp_o` is never raised otherwise.
- R9: D4h while enabled is accepted and raises `offl_start_o` with the done pulse. In that cycle `offl_op_o` equals the LBA Low byte of the request.
- R10: D0h, D5h and D6h while enabled are accepted with no action pulse and no flag change.
- R11: Any subcommand byte outside the set D0h, D3h, D4h, D5h, D6h, D8h, D9h, DAh, DBh is aborted with `rsp_err_o`=1 and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads persistent flags |
| nv_en_i | input | 1 | Persistent SMART-enabled value loaded during reset |
| nv_auto_i | input | 1 | Persistent automatic off-line value loaded during reset |
| cmd_stb_i | input | 1 | One-cycle request strobe |
| cmd_sub_i | input | 8 | Subcommand byte (Features register) |
| cmd_cnt_i | input | 8 | Sector Count byte |
| cmd_lba_i | input | 8 | LBA Low byte |
| rsp_done_o | output | 1 | Completion pulse, one cycle after the strobe |
| rsp_ok_o | output | 1 | Request accepted (valid with done) |
| rsp_err_o | output | 1 | Request aborted with error (valid with done) |
| smart_en_o | output | 1 | Current SMART-enabled flag |
| auto_off_o | output | 1 | Current automatic off-line flag |
| save_o | output | 1 | Attribute save request pulse |
| cmp_o | output | 1 | Threshold compare request pulse |
| offl_start_o | output | 1 | Off-line activity start pulse |
| offl_op_o | output | 8 | Off-line operation code, valid with the start pulse |

## Verification
A wrong enabled flag appears immediately as the wrong status on the next request. A disabled block aborts reads and saves it should accept, and an enabled block accepts them instead of aborting. Both show up in the done cycle, one cycle after the strobe, and `smart_en_o` shows the flag directly. A corrupted automatic off-line flag is visible on `auto_off_o` after the DBh request that changed it. A lost or spurious compare-pending bit shows as a missing or extra `cmp_o` two cycles after a strobe.

// File: rtl/smart_gate_pkg.sv
// Package: subcommand byte values and the decoded action bundle shared
// by the decoder, the state registers and the response stage.
package smart_gate_pkg;

    localparam int CODE_W = 8;

    localparam logic [CODE_W-1:0] SUB_RD_DATA  = 8'hD0;
    localparam logic [CODE_W-1:0] SUB_SAVE     = 8'hD3;
    localparam logic [CODE_W-1:0] SUB_OFFLINE  = 8'hD4;
    localparam logic [CODE_W-1:0] SUB_RD_LOG   = 8'hD5;
    localparam logic [CODE_W-1:0] SUB_WR_LOG   = 8'hD6;
    localparam logic [CODE_W-1:0] SUB_ENABLE   = 8'hD8;
    localparam logic [CODE_W-1:0] SUB_DISABLE  = 8'hD9;
    localparam logic [CODE_W-1:0] SUB_STATUS   = 8'hDA;
    localparam logic [CODE_W-1:0] SUB_AUTO_OFF = 8'hDB;

    localparam logic [CODE_W-1:0] CNT_AUTO_CLR = 8'h00;
    localparam logic [CODE_W-1:0] CNT_AUTO_SET = 8'hF8;

    typedef struct packed {
        logic ok;
        logic err;
        logic set_en;
        logic clr_en;
        logic set_ao;
        logic clr_ao;
        logic save;
        logic cmp;
        logic offl;
    } act_t;

endpackage

// File: rtl/smart_gate_decode.sv
// Module: smart_gate_decode
// Purely combinational classification of one request into an action bundle.
// Assumes the caller qualifies the bundle with the strobe; the outputs are
// meaningless when no request is present.
module smart_gate_decode
    import smart_gate_pkg::*;
(
    input  logic [CODE_W-1:0] sub_i,
    input  logic [CODE_W-1:0] cnt_i,
    input  logic              en_i,
    output act_t              act_o
);

    // Map subcommand, count and current enable state to an action bundle.
    always_comb begin
        act_o = '0;
        if (!en_i) begin
            if (sub_i == SUB_ENABLE) begin
                act_o.ok     = 1'b1;
                act_o.set_en = 1'b1;
            end else begin
                act_o.err = 1'b1;
            end
        end else begin
            unique case (sub_i)
                SUB_RD_DATA, SUB_RD_LOG, SUB_WR_LOG, SUB_ENABLE: act_o.ok = 1'b1;
                SUB_SAVE: begin
                    act_o.ok   = 1'b1;
                    act_o.save = 1'b1;
                end
                SUB_OFFLINE: begin
                    act_o.ok   = 1'b1;
                    act_o.offl = 1'b1;
                end
                SUB_DISABLE: begin
                    act_o.ok     = 1'b1;
                    act_o.clr_en = 1'b1;
                end
                SUB_STATUS: begin
                    act_o.ok   = 1'b1;
                    act_o.save = 1'b1;
                    act_o.cmp  = 1'b1;
                end
                SUB_AUTO_OFF: begin
                    if (cnt_i == CNT_AUTO_CLR) begin
                        act_o.ok     = 1'b1;
                        act_o.clr_ao = 1'b1;
                    end else if (cnt_i == CNT_AUTO_SET) begin
                        act_o.ok     = 1'b1;
                        act_o.set_ao = 1'b1;
                    end else begin
                        act_o.err = 1'b1;
                    end
                end
                default: act_o.err = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/smart_gate_state.sv
// Module: smart_gate_state
// Holds the SMART-enabled and automatic off-line flags. Both load from the
// persistent inputs while reset is low (synchronous, active low) and change
// only on a strobed request whose action bundle asks for it.
module smart_gate_state
    import smart_gate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nv_en_i,
    input  logic              nv_auto_i,
    input  logic              stb_i,
    input  logic [CODE_W-1:0] sub_i,
    input  act_t              act_i,
    output logic              en_o,
    output logic              ao_o
);

    // Enabled flag: persistent load at reset, set/clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n)                    en_o <= nv_en_i;
        else if (stb_i && act_i.set_en) en_o <= 1'b1;
        else if (stb_i && act_i.clr_en) en_o <= 1'b0;
    end

    // Automatic off-line flag: persistent load at reset, set/clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n)                    ao_o <= nv_auto_i;
        else if (stb_i && act_i.set_ao) ao_o <= 1'b1;
        else if (stb_i && act_i.clr_ao) ao_o <= 1'b0;
    end

    AST_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && !en_o && sub_i != SUB_ENABLE) |=> ($stable(en_o) && $stable(ao_o))); // R3
    AST_ENABLE_IDEMPOTENT: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && en_o && sub_i == SUB_ENABLE) |=> (en_o && $stable(ao_o))); // R4
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && en_o && sub_i == SUB_DISABLE) |=> (!en_o && $stable(ao_o))); // R5

endmodule

// File: rtl/smart_gate_resp.sv
// Module: smart_gate_resp
// Registers the response for one strobed request: done, ok/err and the action
// pulses, each lasting one cycle. A status query also leaves a pending bit
// that fires the threshold-compare pulse one cycle after the save pulse.
// Assumes one request per strobe; back-to-back strobes are each answered.
module smart_gate_resp
    import smart_gate_pkg::*;
#(
    parameter int OP_W = 8
)(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stb_i,
    input  act_t            act_i,
    input  logic [OP_W-1:0] op_i,
    output logic            done_o,
    output logic            ok_o,
    output logic            err_o,
    output logic            save_o,
    output logic            cmp_o,
    output logic            offl_o,
    output logic [OP_W-1:0] op_o
);

    logic cmp_pend_q;

    // Completion, status and single-cycle action pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o <= 1'b0;
            ok_o   <= 1'b0;
            err_o  <= 1'b0;
            save_o <= 1'b0;
            offl_o <= 1'b0;
            op_o   <= '0;
        end else begin
            done_o <= stb_i;
            ok_o   <= stb_i && act_i.ok;
            err_o  <= stb_i && act_i.err;
            save_o <= stb_i && act_i.save;
            offl_o <= stb_i && act_i.offl;
            op_o   <= (stb_i && act_i.offl) ? op_i : '0;
        end
    end

    // Compare sequencing: pending with the save pulse, fired on the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_pend_q <= 1'b0;
            cmp_o      <= 1'b0;
        end else begin
            cmp_pend_q <= stb_i && act_i.cmp;
            cmp_o      <= cmp_pend_q;
        end
    end

    AST_DONE_FOLLOWS_STB: assert property (@(posedge clk) disable iff (!rst_n)
        stb_i |=> done_o); // R2
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(stb_i)); // R2
    AST_ONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (ok_o != err_o)); // R2
    AST_ACTIONS_NEED_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (save_o || offl_o) |-> (done_o && ok_o)); // R3
    AST_CMP_AFTER_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_o |-> $past(save_o)); // R8

endmodule

// File: rtl/smart_gate.sv
// Module: smart_gate (top)
// SMART subcommand gating controller: decodes a strobed request against the
// current enable state, updates the persistent flags and answers one cycle
// later with a status and action pulses. Reset is synchronous, active low.
module smart_gate
    import smart_gate_pkg::*;
#(
    parameter int OP_W = 8
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nv_en_i,
    input  logic              nv_auto_i,
    input  logic              cmd_stb_i,
    input  logic [CODE_W-1:0] cmd_sub_i,
    input  logic [CODE_W-1:0] cmd_cnt_i,
    input  logic [OP_W-1:0]   cmd_lba_i,
    output logic              rsp_done_o,
    output logic              rsp_ok_o,
    output logic              rsp_err_o,
    output logic              smart_en_o,
    output logic              auto_off_o,
    output logic              save_o,
    output logic              cmp_o,
    output logic              offl_start_o,
    output logic [OP_W-1:0]   offl_op_o
);

    act_t act;

    smart_gate_decode u_decode (
        .sub_i (cmd_sub_i),
        .cnt_i (cmd_cnt_i),
        .en_i  (smart_en_o),
        .act_o (act)
    );

    smart_gate_state u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .nv_en_i   (nv_en_i),
        .nv_auto_i (nv_auto_i),
        .stb_i     (cmd_stb_i),
        .sub_i     (cmd_sub_i),
        .act_i     (act),
        .en_o      (smart_en_o),
        .ao_o      (auto_off_o)
    );

    smart_gate_resp #(.OP_W(OP_W)) u_resp (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb_i  (cmd_stb_i),
        .act_i  (act),
        .op_i   (cmd_lba_i),
        .done_o (rsp_done_o),
        .ok_o   (rsp_ok_o),
        .err_o  (rsp_err_o),
        .save_o (save_o),
        .cmp_o  (cmp_o),
        .offl_o (offl_start_o),
        .op_o   (offl_op_o)
    );

    AST_AUTO_SET_F8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb_i && smart_en_o && cmd_sub_i == SUB_AUTO_OFF && cmd_cnt_i == CNT_AUTO_SET)
        |=> auto_off_o); // R6
    AST_OFFL_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb_i && smart_en_o && cmd_sub_i == SUB_OFFLINE)
        |=> (offl_start_o && offl_op_o == $past(cmd_lba_i))); // R9

endmodule

// File: tb/smart_gate_bench.sv
// Bench: directed corner cases plus seeded random requests, each compared
// with expectations computed from the requirements.
module smart_gate_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nv_en = 1'b0, nv_auto = 1'b0;
    logic       stb = 1'b0;
    logic [7:0] sub = '0, cnt = '0, lba = '0;
    logic       done, ok, err, en, ao, save, cmp, offl;
    logic [7:0] op;

    int vectors = 0;
    int fails   = 0;
    logic m_en, m_ao;

    always #10 clk = ~clk;

    smart_gate u_smart_gate (
        .clk(clk), .rst_n(rst_n), .nv_en_i(nv_en), .nv_auto_i(nv_auto),
        .cmd_stb_i(stb), .cmd_sub_i(sub), .cmd_cnt_i(cnt), .cmd_lba_i(lba),
        .rsp_done_o(done), .rsp_ok_o(ok), .rsp_err_o(err),
        .smart_en_o(en), .auto_off_o(ao), .save_o(save), .cmp_o(cmp),
        .offl_start_o(offl), .offl_op_o(op)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic bit known(input logic [7:0] s);
        return s inside {8'hD0, 8'hD3, 8'hD4, 8'hD5, 8'hD6, 8'hD8, 8'hD9, 8'hDA, 8'hDB};
    endfunction

    task automatic do_reset(input logic e, input logic a);
        @(negedge clk);
        nv_en = e; nv_auto = a; rst_n = 1'b0; stb = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        m_en = e; m_ao = a;
        chk("R1", "en after reset", {7'd0, en}, {7'd0, e});
        chk("R1", "auto after reset", {7'd0, ao}, {7'd0, a});
        chk("R1", "done after reset", {7'd0, done}, 8'd0);
        chk("R1", "save/cmp/offl after reset", {5'd0, save, cmp, offl}, 8'd0);
    endtask

    task automatic issue(input logic [7:0] s, input logic [7:0] c, input logic [7:0] l);
        logic e_ok, e_save, e_cmp, e_offl, n_en, n_ao;
        string rq;
        e_ok = 1'b0; e_save = 1'b0; e_cmp = 1'b0; e_offl = 1'b0;
        n_en = m_en; n_ao = m_ao;
        if (!m_en) begin
            rq = (s == 8'hD8) ? "R4" : "R3";
            if (s == 8'hD8) begin e_ok = 1'b1; n_en = 1'b1; end
        end else if (!known(s)) rq = "R11";
        else begin
            case (s)
                8'hD3: begin rq = "R7"; e_ok = 1'b1; e_save = 1'b1; end
                8'hDA: begin rq = "R8"; e_ok = 1'b1; e_save = 1'b1; e_cmp = 1'b1; end
                8'hD4: begin rq = "R9"; e_ok = 1'b1; e_offl = 1'b1; end
                8'hD8: begin rq = "R4"; e_ok = 1'b1; end
                8'hD9: begin rq = "R5"; e_ok = 1'b1; n_en = 1'b0; end
                8'hDB: begin
                    rq = "R6";
                    if (c == 8'h00) begin e_ok = 1'b1; n_ao = 1'b0; end
                    else if (c == 8'hF8) begin e_ok = 1'b1; n_ao = 1'b1; end
                end
                default: begin rq = "R10"; e_ok = 1'b1; end
            endcase
        end
        @(negedge clk);
        stb = 1'b1; sub = s; cnt = c; lba = l;
        @(negedge clk);
        stb = 1'b0; sub = $urandom; cnt = $urandom; lba = $urandom;
        chk("R2", "done", {7'd0, done}, 8'd1);
        chk(rq, "ok/err", {6'd0, ok, err}, {6'd0, e_ok, !e_ok});
        chk(rq, "save", {7'd0, save}, {7'd0, e_save});
        chk(rq, "offl", {7'd0, offl}, {7'd0, e_offl});
        if (e_offl) chk("R9", "offl op", op, l);
        chk(rq, "en", {7'd0, en}, {7'd0, n_en});
        chk(rq, "auto", {7'd0, ao}, {7'd0, n_ao});
        chk("R8", "cmp not with save", {7'd0, cmp}, 8'd0);
        m_en = n_en; m_ao = n_ao;
        @(negedge clk);
        chk("R2", "single done", {7'd0, done}, 8'd0);
        chk("R8", "cmp after save", {7'd0, cmp}, {7'd0, e_cmp});
    endtask

    initial begin
        process::self().srandom(32'd1234);
        do_reset(1'b0, 1'b1);
        issue(8'hD0, 8'h00, 8'h00);        // R3 read while disabled
        issue(8'hDB, 8'hF8, 8'h00);        // R3 auto control while disabled
        issue(8'hD9, 8'h00, 8'h00);        // R3 disable while disabled
        issue(8'hD8, 8'h00, 8'h00);        // R4 enable
        issue(8'hD8, 8'h00, 8'h00);        // R4 enable again
        issue(8'hDB, 8'h00, 8'h00);        // R6 clear
        issue(8'hDB, 8'h05, 8'h00);        // R6 other value
        issue(8'hDB, 8'hF8, 8'h00);        // R6 set
        issue(8'hDB, 8'h01, 8'h00);        // R6 other value keeps set
        issue(8'hD3, 8'h00, 8'h00);        // R7
        issue(8'hDA, 8'h00, 8'h00);        // R8
        issue(8'hD4, 8'h00, 8'h81);        // R9
        issue(8'hD5, 8'h01, 8'h06);        // R10
        issue(8'hD6, 8'h01, 8'h09);        // R10
        issue(8'hD1, 8'h00, 8'h00);        // R11
        issue(8'hB0, 8'h00, 8'h00);        // R11
        issue(8'hD9, 8'h00, 8'h00);        // R5
        issue(8'hDA, 8'h00, 8'h00);        // R3 status while disabled
        do_reset(1'b1, 1'b0);              // R1 other persistent values
        for (int i = 0; i < 400; i++) begin
            logic [7:0] s, c;
            int pick;
            pick = $urandom_range(0, 11);
            case (pick)
                0: s = 8'hD0; 1: s = 8'hD3; 2: s = 8'hD4; 3: s = 8'hD5;
                4: s = 8'hD6; 5: s = 8'hD8; 6: s = 8'hD9; 7: s = 8'hDA;
                8, 9: s = 8'hDB; default: s = $urandom;
            endcase
            pick = $urandom_range(0, 2);
            c = (pick == 0) ? 8'h00 : (pick == 1) ? 8'hF8 : 8'($urandom);
            issue(s, c, 8'($urandom));
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule